// File: doc/BRIEF.md
# Sensor Fault Supervisor

This block watches the health of a sensor's conditioning logic and keeps a sticky record of any problem it finds. It has three fault sources. The first is a low-supply flag from an analog comparator. The second is a frequency check on the internal oscillator, timed against the reference clock. The third is a parity check over a static word of stored trim bits. Any active source sets a fault latch, and it also sets the matching bit in a sticky cause register.

The status output is the fault latch ORed with the live level of the self-test input. The self-test input is synchronized inside the block. Its rising edge is the only event that clears the latch and the cause register. That clear is refused while any fault source is still active. After reset the latch is set, so the host must perform one self-test while the sensor is healthy before status can read low.

Top module: `sfs_fault_supervisor`

## Requirements
- R1: `status_o` equals `fault_o` ORed with the current level of `selftest_i`. The raw input is used, with no synchronizer delay.
- R2: During and right after reset, `fault_o` is 1, `cause_o` is 0 and `status_o` is 1.
- R3: When `lowv_i` is high, it passes a two-flop synchronizer and then sets `fault_o` and cause bit 0. This happens on the third rising clock edge after the input changes.
- R4: The clock monitor counts oscillator rising edges over each window of `WINDOW` reference cycles. If a window ends with fewer than `MIN_EDGES` edges, the clock fault becomes active; this includes a stopped oscillator. The clock fault sets `fault_o` and cause bit 1. A clock fault is only raised or dropped at a window boundary.
- R5: An odd number of ones in `trim_i` is a parity fault. It sets `fault_o` and cause bit 2 on the next rising clock edge.
- R6: A rising edge on `selftest_i` clears `fault_o` and all of `cause_o`, provided no fault source is active. The edge is synchronized through two flops and becomes a pulse exactly one clock wide. The clear takes effect on the third rising clock edge after the input rises.
- R7: A clear is refused while any fault source is active. This also holds when a fault source and the clear pulse arrive in the same cycle: setting wins.
- R8: Holding `selftest_i` high clears only once. A fault that appears later while the input stays high sets the latch, and the latch stays set.
- R9: Cause bits are sticky. After a fault source goes inactive, `fault_o` and its cause bit remain set until a clear succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset (also sampled by the oscillator-domain flop) |
| osc_clk | input | 1 | Internal oscillator being monitored |
| lowv_i | input | 1 | Asynchronous low-supply flag |
| trim_i | input | TRIM_W | Static stored trim word |
| selftest_i | input | 1 | Asynchronous self-test request |
| status_o | output | 1 | Fault latch ORed with live self-test level |
| fault_o | output | 1 | Fault latch state |
| cause_o | output | 3 | Sticky causes: bit0 low supply, bit1 clock, bit2 parity |

## Verification
The bench builds the block with `WINDOW` = 32 and `MIN_EDGES` = 8, so a full monitor window lasts only 256 ns. At those settings, a healthy 20 ns oscillator gives about 12 edges per window, a slowed 80 ns oscillator gives about 3, and a stopped oscillator gives none. Each of these cases, and the recovery from them, therefore fits in a few hundred cycles. `TRIM_W` = 12 lets the bench choose both even and odd trim patterns. The bench also raises the parity fault in the exact cycle that the clear pulse is live, to check the priority rule.

// File: rtl/sfs_pkg.sv
// Shared definitions for the sensor fault supervisor.
// Assumes cause bit positions are fixed and known to software-visible logic.
package sfs_pkg;
    localparam int CAUSE_W    = 3;
    localparam int CAUSE_LOWV = 0;
    localparam int CAUSE_CLK  = 1;
    localparam int CAUSE_PAR  = 2;
    typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/sfs_sync2.sv
// Two-flop synchronizer for a single asynchronous bit.
// Assumes the input is a level that stays stable for several destination cycles.
module sfs_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic meta_q;

    // Capture the asynchronous level through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_o    <= RST_VAL;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/sfs_st_edge.sv
// Self-test edge detector: synchronizes the request and emits a one-cycle
// pulse on each rising edge. Assumes the request is held for >= 2 cycles.
module sfs_st_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic st_i,
    output logic pulse_o
);
    logic st_sync;
    logic st_prev;

    sfs_sync2 #(.RST_VAL(1'b0)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (st_i),
        .q_o  (st_sync)
    );

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) st_prev <= 1'b0;
        else        st_prev <= st_sync;
    end

    assign pulse_o = st_sync & ~st_prev;

    assert_pulse_one_wide_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
endmodule

// File: rtl/sfs_clk_mon.sv
// Oscillator frequency monitor. A divide-by-two flop in the oscillator domain
// toggles on every oscillator edge; the reference domain synchronizes it and
// counts transitions over WINDOW reference cycles. Assumes the oscillator runs
// below half the reference frequency and that rst_n is held long enough to be
// seen by the oscillator domain.
module sfs_clk_mon #(
    parameter int WINDOW    = 256,
    parameter int MIN_EDGES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_clk,
    output logic clk_fault_o
);
    localparam int WIN_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam int CNT_W = $clog2(MIN_EDGES + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW - 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(MIN_EDGES);

    logic             osc_tgl;
    logic             tgl_sync;
    logic             tgl_prev;
    logic             osc_edge;
    logic [WIN_W-1:0] win_cnt;
    logic [CNT_W-1:0] edge_cnt;
    logic [CNT_W-1:0] edge_cnt_nx;
    logic             win_end;

    // Oscillator-domain toggle: one transition per oscillator rising edge.
    always_ff @(posedge osc_clk) begin
        if (!rst_n) osc_tgl <= 1'b0;
        else        osc_tgl <= ~osc_tgl;
    end

    sfs_sync2 #(.RST_VAL(1'b0)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (osc_tgl),
        .q_o  (tgl_sync)
    );

    // Keep the previous synchronized toggle to spot transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) tgl_prev <= 1'b0;
        else        tgl_prev <= tgl_sync;
    end

    assign osc_edge    = tgl_sync ^ tgl_prev;
    assign win_end     = (win_cnt == WIN_LAST);
    assign edge_cnt_nx = (osc_edge && edge_cnt != CNT_SAT) ? edge_cnt + 1'b1 : edge_cnt;

    // Step the window timer and restart it at the window boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)       win_cnt <= '0;
        else if (win_end) win_cnt <= '0;
        else              win_cnt <= win_cnt + 1'b1;
    end

    // Count edges inside the window, saturating at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n)       edge_cnt <= '0;
        else if (win_end) edge_cnt <= '0;
        else              edge_cnt <= edge_cnt_nx;
    end

    // Judge the window at its last cycle and hold the verdict.
    always_ff @(posedge clk) begin
        if (!rst_n)       clk_fault_o <= 1'b0;
        else if (win_end) clk_fault_o <= (edge_cnt_nx < CNT_SAT);
    end

    assert_verdict_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_fault_o) |-> ($past(win_cnt) == WIN_LAST));
endmodule

// File: rtl/sfs_fault_latch.sv
// Sticky fault latch and cause register. Any active condition sets both;
// a clear pulse resets both only when no condition is active (set wins).
// Assumes conditions are already in the clk domain.
module sfs_fault_latch
    import sfs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  cause_t cond_i,
    input  logic   clr_i,
    output logic   fault_o,
    output cause_t cause_o
);
    logic any_fault;
    assign any_fault = |cond_i;

    // Latch update: set has priority, clear only when healthy.
    always_ff @(posedge clk) begin
        if (!rst_n)         fault_o <= 1'b1;
        else if (any_fault) fault_o <= 1'b1;
        else if (clr_i)     fault_o <= 1'b0;
    end

    // Cause register accumulates conditions and clears with the latch.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cause_o <= '0;
        else if (clr_i && !any_fault) cause_o <= '0;
        else                          cause_o <= cause_o | cond_i;
    end

    assert_set_on_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        any_fault |=> fault_o);
    assert_clear_needs_healthy_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_o) |-> ($past(clr_i) && !$past(any_fault)));
    assert_cause_implies_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|cause_o) |-> fault_o);
    assert_latch_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && !clr_i) |=> fault_o);
endmodule

// File: rtl/sfs_fault_supervisor.sv
// Top of the sensor fault supervisor: gathers low-supply, oscillator and trim
// parity conditions into a sticky latch and drives status. Assumes trim_i is
// static and lowv_i / selftest_i are asynchronous levels.
module sfs_fault_supervisor
    import sfs_pkg::*;
#(
    parameter int TRIM_W    = 32,
    parameter int WINDOW    = 256,
    parameter int MIN_EDGES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_clk,
    input  logic              lowv_i,
    input  logic [TRIM_W-1:0] trim_i,
    input  logic              selftest_i,
    output logic              status_o,
    output logic              fault_o,
    output logic [CAUSE_W-1:0] cause_o
);
    logic   lowv_sync;
    logic   clk_fault;
    logic   clr_pulse;
    cause_t cond;
    cause_t cause_q;

    sfs_sync2 #(.RST_VAL(1'b0)) u_lowv_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (lowv_i),
        .q_o  (lowv_sync)
    );

    sfs_clk_mon #(.WINDOW(WINDOW), .MIN_EDGES(MIN_EDGES)) u_clk_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_clk    (osc_clk),
        .clk_fault_o(clk_fault)
    );

    sfs_st_edge u_st_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .st_i   (selftest_i),
        .pulse_o(clr_pulse)
    );

    // Assemble condition vector; parity is the live XOR reduction of trim.
    always_comb begin
        cond             = '0;
        cond[CAUSE_LOWV] = lowv_sync;
        cond[CAUSE_CLK]  = clk_fault;
        cond[CAUSE_PAR]  = ^trim_i;
    end

    sfs_fault_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond_i (cond),
        .clr_i  (clr_pulse),
        .fault_o(fault_o),
        .cause_o(cause_q)
    );

    assign cause_o  = cause_q;
    assign status_o = fault_o | selftest_i;

    assert_status_follows_selftest_R1: assert property (@(posedge clk) disable iff (!rst_n)
        selftest_i |-> status_o);
endmodule

// File: tb/sfs_fault_supervisor_test.sv
`timescale 1ns/1ps
module sfs_fault_supervisor_test;
    localparam int TRIM_W = 12;
    localparam logic [TRIM_W-1:0] TRIM_EVEN = 12'hA5C;
    localparam logic [TRIM_W-1:0] TRIM_ODD  = 12'hA5D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_clk = 1'b0;
    logic lowv = 1'b0;
    logic [TRIM_W-1:0] trim = TRIM_EVEN;
    logic st = 1'b0;
    logic status;
    logic fault;
    logic [2:0] cause;

    int checks = 0;
    int errors = 0;
    int osc_half = 10;
    logic osc_stop = 1'b0;
    logic done = 1'b0;

    sfs_fault_supervisor #(.TRIM_W(TRIM_W), .WINDOW(32), .MIN_EDGES(8)) uut (
        .clk(clk), .rst_n(rst_n), .osc_clk(osc_clk), .lowv_i(lowv),
        .trim_i(trim), .selftest_i(st), .status_o(status),
        .fault_o(fault), .cause_o(cause)
    );

    always #4 clk = ~clk;
    always begin
        #(osc_half);
        if (!osc_stop) osc_clk = ~osc_clk;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    // Raise self-test, let the edge reach the latch, then drop it.
    task automatic pulse_st();
        st = 1'b1;
        cyc(4);
        st = 1'b0;
        cyc(1);
    endtask

    task automatic t_reset();
        chk("R2 fault", fault, 1);
        chk("R2 cause", cause, 0);
        chk("R2 status", status, 1);
    endtask

    task automatic t_clear();
        cyc(70);
        st = 1'b1;
        cyc(2);
        chk("R6 not yet cleared", fault, 1);
        cyc(1);
        chk("R6 cleared on third edge", fault, 0);
        chk("R1 status with st high", status, 1);
        st = 1'b0;
        #1;
        chk("R1 status low", status, 0);
        chk("R6 cause cleared", cause, 0);
    endtask

    task automatic t_lowv();
        lowv = 1'b1;
        cyc(2);
        chk("R3 not yet", fault, 0);
        cyc(1);
        chk("R3 latch set", fault, 1);
        chk("R3 cause", cause, 3'b001);
        pulse_st();
        chk("R7 clear refused", fault, 1);
        lowv = 1'b0;
        cyc(5);
        chk("R9 sticky latch", fault, 1);
        chk("R9 sticky cause", cause, 3'b001);
        chk("R1 status follows latch", status, 1);
        pulse_st();
        chk("R6 clear after recovery", {fault, cause}, 0);
    endtask

    task automatic t_parity();
        trim = TRIM_ODD;
        cyc(1);
        chk("R5 latch set", fault, 1);
        chk("R5 cause", cause, 3'b100);
        trim = TRIM_EVEN;
        pulse_st();
        chk("R5 clear after even", {fault, cause}, 0);
    endtask

    task automatic t_clock();
        osc_half = 40;
        cyc(100);
        chk("R4 slow osc", cause, 3'b010);
        osc_half = 10;
        cyc(100);
        pulse_st();
        chk("R4 recover", {fault, cause}, 0);
        osc_stop = 1'b1;
        cyc(100);
        chk("R4 stopped osc", {fault, cause}, 4'b1010);
        osc_stop = 1'b0;
        cyc(100);
        pulse_st();
        chk("R4 recover stop", {fault, cause}, 0);
    endtask

    task automatic t_held();
        st = 1'b1;
        cyc(10);
        trim = TRIM_ODD;
        cyc(1);
        trim = TRIM_EVEN;
        cyc(10);
        chk("R8 level does not clear", fault, 1);
        chk("R8 cause", cause, 3'b100);
        st = 1'b0;
        cyc(2);
        pulse_st();
        chk("R8 cleared by new edge", fault, 0);
    endtask

    task automatic t_simul();
        st = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1 trim = TRIM_ODD;
        cyc(1);
        chk("R7 set wins over clear", fault, 1);
        chk("R7 cause kept", cause, 3'b100);
        trim = TRIM_EVEN;
        st = 1'b0;
        cyc(2);
        pulse_st();
        chk("R7 later clear", fault, 0);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(5);
        t_reset();
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_clear();
        t_lowv();
        t_parity();
        t_clock();
        t_held();
        t_simul();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule